// File: doc/BRIEF.md
# Boot Strap Latch and Chip-Select Decoder

This block captures the boot-configuration straps while power-on reset is held. It keeps them for the whole session once reset is released. The media-change strap is active low. A low value selects internal boot. In that mode the processor starts from on-chip memory and stays in standby until a wake-up request arrives. A high value selects external boot. In that mode the processor runs as soon as reset ends, and two width straps give the bus width of the boot device.

Each bus access presents a 32-bit address and a valid strobe. The top address nibble picks one of eight selects. Selects 7 and 6 are internal only and active high. Selects 5 down to 0 drive active-low pins. The address-to-select map depends on the latched boot mode. Addresses at or above 0x8000_0000 select nothing. The block also reports the boot-width code, a flag for the illegal width strap, and a run-enable for the processor.

Top module: `boot_cs_decode`

## Requirements
- R1: The straps are sampled at every clock edge while `por_n` is low. The value from the last such edge is held unchanged for as long as `por_n` stays high, so later strap changes have no effect on the map or on the width outputs.
- R2: Internal boot (`media_n` latched 0) maps top nibbles as follows: 0x0 asserts select 7 (`cs_int[1]`), 0x1 asserts select 6 (`cs_int[0]`), and 0x2 through 0x7 assert `ncs_n[5]` down to `ncs_n[0]` in that order.
- R3: External boot (`media_n` latched 1) maps top nibble n (0 to 7) to select n. Selects 0 to 5 are `ncs_n[n]` driven low, and 6 and 7 are `cs_int[0]` and `cs_int[1]` driven high.
- R4: No select is active when `acc_valid` is low, when the top nibble is 0x8 or above, or while `por_n` is low. An idle state means `cs_int`=00 and `ncs_n`=111111.
- R5: In external boot, latched width straps 00, 01 and 10 appear unchanged on `width_code` (00 means 32-bit, 01 means 8-bit, 10 means 16-bit). In internal boot, `width_code` is 00.
- R6: In external boot, latched width straps 11 set `width_bad` to 1 and force `width_code` to 00. Otherwise `width_bad` is 0.
- R7: In external boot, `run_en` is 0 during reset and becomes 1 at the first clock edge with `por_n` high.
- R8: In internal boot, `run_en` becomes 1 at the first clock edge where `wake` is sampled 1 after being sampled 0. A `wake` already high at release does not count. Once set, `run_en` stays 1 until `por_n` goes low.
- R9: At most one of the eight selects is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| media_n | input | 1 | Boot-source strap, 0 selects internal boot |
| wstrap | input | 2 | Boot-width straps |
| wake | input | 1 | Wake-up request |
| addr | input | 32 | Bus access address |
| acc_valid | input | 1 | Access valid strobe |
| cs_int | output | 2 | Internal selects: bit 1 is select 7, bit 0 is select 6, active high |
| ncs_n | output | 6 | External selects 5..0, active low |
| width_code | output | 2 | Boot-device width code |
| width_bad | output | 1 | Illegal width strap seen |
| run_en | output | 1 | Processor may leave standby |

## Verification
Address decode is combinational, so every select is checked one time unit after the address and strobe change, inside the same low clock phase. The strap latch and `run_en` update at a rising edge. Inputs change on falling edges. The bench reads the value just before the edge that should move it, and again at the following falling edge. It then confirms that `run_en` does not move early, neither on release in internal mode nor in the same phase as a new `wake` edge.

// File: rtl/boot_cs_decode.sv
module boot_cs_decode #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          media_n,
  input  logic [1:0]    wstrap,
  input  logic          wake,
  input  logic [AW-1:0] addr,
  input  logic          acc_valid,
  output logic [1:0]    cs_int,
  output logic [5:0]    ncs_n,
  output logic [1:0]    width_code,
  output logic          width_bad,
  output logic          run_en
);
  localparam int NSEL = 8;

  logic       boot_int_q;
  logic [1:0] wcode_q;
  logic       wake_q;
  logic       run_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      boot_int_q <= ~media_n;
      wcode_q    <= wstrap;
      wake_q     <= wake;
      run_q      <= 1'b0;
    end else begin
      wake_q <= wake;
      run_q  <= run_q | ~boot_int_q | (wake & ~wake_q);
    end
  end

  logic [3:0]      nib;
  logic [2:0]      idx;
  logic [NSEL-1:0] sel;

  assign nib = addr[AW-1 -: 4];
  assign idx = boot_int_q ? (3'd7 - nib[2:0]) : nib[2:0];
  assign sel = (acc_valid && por_n && !nib[3]) ? (NSEL'(1) << idx) : '0;

  assign cs_int     = sel[7:6];
  assign ncs_n      = ~sel[5:0];
  assign width_bad  = ~boot_int_q & (wcode_q == 2'b11);
  assign width_code = (boot_int_q || wcode_q == 2'b11) ? 2'b00 : wcode_q;
  assign run_en     = run_q;

  assert_one_sel_R9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({cs_int, ~ncs_n}));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
    !acc_valid |-> (cs_int == 2'b00 && ncs_n == 6'h3F));

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> ($stable(width_code) && $stable(width_bad)));

  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    run_en |=> run_en);

  assert_width_legal_R6: assert property (@(posedge clk) disable iff (!por_n)
    width_code != 2'b11);
endmodule

// File: tb/boot_cs_decode_tb_top.sv
`timescale 1ns/1ps
module boot_cs_decode_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        media_n = 1'b1;
  logic [1:0]  wstrap = 2'b00;
  logic        wake = 1'b0;
  logic [31:0] addr = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  cs_int;
  logic [5:0]  ncs_n;
  logic [1:0]  width_code;
  logic        width_bad;
  logic        run_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_cs_decode dut_i (
    .clk(clk), .por_n(por_n), .media_n(media_n), .wstrap(wstrap), .wake(wake),
    .addr(addr), .acc_valid(acc_valid), .cs_int(cs_int), .ncs_n(ncs_n),
    .width_code(width_code), .width_bad(width_bad), .run_en(run_en)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input bit internal, input logic [3:0] nib, input bit vld);
    logic [7:0] s;
    s = '0;
    if (vld && !nib[3]) begin
      if (internal) s[7 - nib[2:0]] = 1'b1;
      else          s[nib[2:0]] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [7:0] got_sel();
    return {cs_int, ~ncs_n};
  endfunction

  task automatic boot(input logic med, input logic [1:0] ws, input logic wk);
    @(negedge clk);
    por_n = 0; media_n = med; wstrap = ws; wake = wk;
    acc_valid = 1; addr = 32'h0000_0000;
    repeat (3) @(negedge clk);
    #1;
    chk("R4", "select during reset", got_sel(), 8'h00);
    chk("R7", "run_en during reset", {7'b0, run_en}, 8'h00);
    @(negedge clk);
    por_n = 1;
    #1;
    chk("R7", "run_en before first edge", {7'b0, run_en}, 8'h00);
    @(negedge clk);
  endtask

  task automatic sweep(input bit internal, input string req);
    for (int n = 0; n < 16; n++) begin
      addr = {n[3:0], 28'h123_4567};
      acc_valid = 1;
      #1;
      chk(n >= 8 ? "R4" : req, $sformatf("nibble %0d", n), got_sel(), exp_sel(internal, n[3:0], 1'b1));
      acc_valid = 0;
      #1;
      chk("R4", $sformatf("strobe low nibble %0d", n), got_sel(), 8'h00);
      @(negedge clk);
    end
  endtask

  task automatic t_external(input logic [1:0] ws);
    boot(1'b1, ws, 1'b0);
    chk("R7", "run_en after release", {7'b0, run_en}, 8'h01);
    chk(ws == 2'b11 ? "R6" : "R5", "width_code", {6'b0, width_code}, ws == 2'b11 ? 8'h00 : {6'b0, ws});
    chk("R6", "width_bad", {7'b0, width_bad}, {7'b0, ws == 2'b11});
    sweep(1'b0, "R3");
  endtask

  task automatic t_internal();
    boot(1'b0, 2'b01, 1'b1);
    repeat (2) @(negedge clk);
    #1;
    chk("R8", "held wake does not run", {7'b0, run_en}, 8'h00);
    chk("R5", "internal width_code", {6'b0, width_code}, 8'h00);
    chk("R6", "internal width_bad", {7'b0, width_bad}, 8'h00);
    sweep(1'b1, "R2");
    wake = 0;
    @(negedge clk);
    wake = 1;
    #1;
    chk("R8", "run_en before wake edge", {7'b0, run_en}, 8'h00);
    @(negedge clk);
    chk("R8", "run_en after wake edge", {7'b0, run_en}, 8'h01);
    wake = 0;
    repeat (4) @(negedge clk);
    chk("R8", "run_en sticky", {7'b0, run_en}, 8'h01);
  endtask

  task automatic t_hold();
    boot(1'b1, 2'b10, 1'b0);
    media_n = 0; wstrap = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "width held", {6'b0, width_code}, 8'h02);
    chk("R1", "bad flag held", {7'b0, width_bad}, 8'h00);
    addr = 32'h1000_0000; acc_valid = 1;
    #1;
    chk("R1", "map held external", got_sel(), 8'h02);
    acc_valid = 0;
    boot(1'b0, 2'b11, 1'b0);
    media_n = 1;
    repeat (2) @(negedge clk);
    addr = 32'h7000_0000; acc_valid = 1;
    #1;
    chk("R1", "map held internal", got_sel(), 8'h01);
    chk("R8", "no wake no run", {7'b0, run_en}, 8'h00);
    acc_valid = 0;
  endtask

  initial begin
    t_external(2'b00);
    t_external(2'b01);
    t_external(2'b10);
    t_external(2'b11);
    t_internal();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule